// File: doc/BRIEF.md
# Single-Burst AXI4 Memory Mover

This block converts one request at a time into an AXI4 memory burst. It has two sides that work on their own, a write side and a read side. Each side has a command port and a data stream. The command port carries a byte start address, a beat count and a valid/ready pair. The data stream carries data with a valid/ready pair. For a write, the block issues one write-address burst. It then moves words from the write stream onto the W channel and waits for the write response. For a read, it issues one read-address burst and passes the R beats out on the read stream.

The ready output of each command port also serves as the busy indication for that side. Ready is high only while the side is idle. It goes low in the cycle after a request is taken. It returns high only when the burst has fully completed. For a write, that point is the accepted write response. For a read, it is the transfer of the last read word.

Both data streams follow valid/ready rules with back-pressure. The write stream is consumed only while the memory side accepts W beats. Its ready is WREADY, gated by the data phase. The read stream is a direct pass-through of RVALID, RREADY and RDATA, so the consumer's ready throttles the memory directly. The requester must keep every request inside one 4096-byte page and aligned to a data word.

Top module: `burst_dma_master`

## Requirements
- R1: After a synchronous reset, both command ready outputs are high. AWVALID, WVALID, ARVALID, BREADY and RREADY are low, and both error flags are low.
- R2: Each request produces exactly one address beat. The address equals the command address and the length field equals the command count. The size field is 3 (8-byte beats), the burst field is 2'b01 (incrementing) and WSTRB is all ones. Address and length hold steady while the address valid waits for ready.
- R3: A request is taken in a cycle where command valid and command ready are both high. From the next cycle on, command ready stays low until that burst completes.
- R4: Write command ready returns high in the cycle right after the write response handshake, and not before.
- R5: W beats begin only after the write address handshake. Each W beat carries the current write stream word, and WVALID equals the stream valid. The stream ready equals WREADY during the data phase and is low otherwise. WLAST is high exactly on beat number count+1 (counting from 1) and on no other beat.
- R6: During the read data phase, the read stream valid equals RVALID, the read stream data equals RDATA, and RREADY equals the stream ready. RREADY is low outside the data phase. Read command ready returns high in the cycle right after the handshake of the beat carrying RLAST.
- R7: A write response other than OKAY (value 0) sets the write error flag, and an RRESP other than OKAY on any read beat sets the read error flag. Each flag then stays high until reset, and neither one stops further transfers.
- R8: The write and read sides run at the same time without affecting each other's timing or data.
- R9: A count of 0 moves one word, and WLAST is high on that first W beat. The largest count, 2**COUNT_WIDTH-1, moves 256 words by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_cmd_addr | input | ADDR_W | Write request byte address, word aligned |
| wr_cmd_count | input | CNT_W | Write request words minus one |
| wr_cmd_valid | input | 1 | Write request valid |
| wr_cmd_ready | output | 1 | Write side idle / request accepted |
| wr_data | input | DATA_W | Write stream data |
| wr_data_valid | input | 1 | Write stream valid |
| wr_data_ready | output | 1 | Write stream ready |
| rd_cmd_addr | input | ADDR_W | Read request byte address, word aligned |
| rd_cmd_count | input | CNT_W | Read request words minus one |
| rd_cmd_valid | input | 1 | Read request valid |
| rd_cmd_ready | output | 1 | Read side idle / request accepted |
| rd_data | output | DATA_W | Read stream data |
| rd_data_valid | output | 1 | Read stream valid |
| rd_data_ready | input | 1 | Read stream ready |
| awaddr | output | ADDR_W | Write address |
| awlen | output | CNT_W | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte strobes |
| wlast | output | 1 | Last write beat |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read address |
| arlen | output | CNT_W | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last read beat |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| wr_err | output | 1 | Sticky write error flag |
| rd_err | output | 1 | Sticky read error flag |

## Verification
Every handshake changes the block's state at the next clock edge. So the address valid, response ready and command ready due after a handshake appear one cycle later, while the stream-to-channel pass-throughs hold within the same cycle. The bench model works out, from the stimulus it has applied, which handshakes fall on the coming edge. It advances its phase and beat count by those handshakes. At the next falling edge it compares every output against the model's state, so each same-cycle result and each one-cycle-late result is checked in exactly the cycle it is due. Error flags are compared one cycle after the response handshake that sets them.

// File: rtl/burst_dma_pkg.sv
package burst_dma_pkg;
  typedef enum logic [1:0] {
    WS_IDLE,
    WS_ADDR,
    WS_DATA,
    WS_RESP
  } wr_state_t;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_ADDR,
    RS_DATA
  } rd_state_t;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/dma_err_sticky.sv
module dma_err_sticky (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (hit)
      flag <= 1'b1;
  end
endmodule

// File: rtl/dma_wr_engine.sv
module dma_wr_engine
  import burst_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 64,
  parameter logic [2:0] SIZE_CODE = 3'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [CNT_W-1:0]  awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic              err
);
  wr_state_t         state;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  len_q;
  logic [CNT_W-1:0]  beats_left;
  logic              in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WS_IDLE;
      addr_q     <= '0;
      len_q      <= '0;
      beats_left <= '0;
    end else begin
      case (state)
        WS_IDLE: if (cmd_valid) begin
          addr_q     <= cmd_addr;
          len_q      <= cmd_count;
          beats_left <= cmd_count;
          state      <= WS_ADDR;
        end
        WS_ADDR: if (awready) state <= WS_DATA;
        WS_DATA: if (s_valid && wready) begin
          if (beats_left == '0) state <= WS_RESP;
          else beats_left <= beats_left - 1'b1;
        end
        WS_RESP: if (bvalid) state <= WS_IDLE;
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign in_data   = (state == WS_DATA);
  assign cmd_ready = (state == WS_IDLE);
  assign awaddr    = addr_q;
  assign awlen     = len_q;
  assign awsize    = SIZE_CODE;
  assign awburst   = BURST_INCR;
  assign awvalid   = (state == WS_ADDR);
  assign wdata     = s_data;
  assign wstrb     = '1;
  assign wvalid    = in_data && s_valid;
  assign wlast     = in_data && (beats_left == '0);
  assign s_ready   = in_data && wready;
  assign bready    = (state == WS_RESP);

  dma_err_sticky u_err (
    .clk  (clk),
    .rst  (rst),
    .hit  (bvalid && bready && (bresp != RESP_OKAY)),
    .flag (err)
  );
endmodule

// File: rtl/dma_rd_engine.sv
module dma_rd_engine
  import burst_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 64,
  parameter logic [2:0] SIZE_CODE = 3'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] araddr,
  output logic [CNT_W-1:0]  arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast,
  input  logic              rvalid,
  output logic              rready,
  output logic              err
);
  rd_state_t         state;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  len_q;
  logic              in_data;
  logic              beat_hs;

  assign in_data = (state == RS_DATA);
  assign beat_hs = in_data && rvalid && m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RS_IDLE;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      case (state)
        RS_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          len_q  <= cmd_count;
          state  <= RS_ADDR;
        end
        RS_ADDR: if (arready) state <= RS_DATA;
        RS_DATA: if (beat_hs && rlast) state <= RS_IDLE;
        default: state <= RS_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == RS_IDLE);
  assign araddr    = addr_q;
  assign arlen     = len_q;
  assign arsize    = SIZE_CODE;
  assign arburst   = BURST_INCR;
  assign arvalid   = (state == RS_ADDR);
  assign m_data    = rdata;
  assign m_valid   = in_data && rvalid;
  assign rready    = in_data && m_ready;

  dma_err_sticky u_err (
    .clk  (clk),
    .rst  (rst),
    .hit  (beat_hs && (rresp != RESP_OKAY)),
    .flag (err)
  );
endmodule

// File: rtl/burst_dma_master.sv
module burst_dma_master #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_cmd_addr,
  input  logic [CNT_W-1:0]  wr_cmd_count,
  input  logic              wr_cmd_valid,
  output logic              wr_cmd_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_data_valid,
  output logic              wr_data_ready,
  input  logic [ADDR_W-1:0] rd_cmd_addr,
  input  logic [CNT_W-1:0]  rd_cmd_count,
  input  logic              rd_cmd_valid,
  output logic              rd_cmd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_valid,
  input  logic              rd_data_ready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [CNT_W-1:0]  awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic [ADDR_W-1:0] araddr,
  output logic [CNT_W-1:0]  arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast,
  input  logic              rvalid,
  output logic              rready,
  output logic              wr_err,
  output logic              rd_err
);
  localparam int         BYTES_PER_BEAT = DATA_W / 8;
  localparam logic [2:0] SIZE_CODE      = 3'($clog2(BYTES_PER_BEAT));

  dma_wr_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .SIZE_CODE(SIZE_CODE)
  ) u_wr (
    .clk       (clk),
    .rst       (rst),
    .cmd_addr  (wr_cmd_addr),
    .cmd_count (wr_cmd_count),
    .cmd_valid (wr_cmd_valid),
    .cmd_ready (wr_cmd_ready),
    .s_data    (wr_data),
    .s_valid   (wr_data_valid),
    .s_ready   (wr_data_ready),
    .awaddr    (awaddr),
    .awlen     (awlen),
    .awsize    (awsize),
    .awburst   (awburst),
    .awvalid   (awvalid),
    .awready   (awready),
    .wdata     (wdata),
    .wstrb     (wstrb),
    .wlast     (wlast),
    .wvalid    (wvalid),
    .wready    (wready),
    .bresp     (bresp),
    .bvalid    (bvalid),
    .bready    (bready),
    .err       (wr_err)
  );

  dma_rd_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .SIZE_CODE(SIZE_CODE)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .cmd_addr  (rd_cmd_addr),
    .cmd_count (rd_cmd_count),
    .cmd_valid (rd_cmd_valid),
    .cmd_ready (rd_cmd_ready),
    .m_data    (rd_data),
    .m_valid   (rd_data_valid),
    .m_ready   (rd_data_ready),
    .araddr    (araddr),
    .arlen     (arlen),
    .arsize    (arsize),
    .arburst   (arburst),
    .arvalid   (arvalid),
    .arready   (arready),
    .rdata     (rdata),
    .rresp     (rresp),
    .rlast     (rlast),
    .rvalid    (rvalid),
    .rready    (rready),
    .err       (rd_err)
  );
endmodule

// File: rtl/burst_dma_checks.sv
module burst_dma_checks #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_cmd_valid,
  input logic              wr_cmd_ready,
  input logic              rd_cmd_valid,
  input logic              rd_cmd_ready,
  input logic [ADDR_W-1:0] awaddr,
  input logic [CNT_W-1:0]  awlen,
  input logic              awvalid,
  input logic              awready,
  input logic              wvalid,
  input logic              wready,
  input logic              wlast,
  input logic              bvalid,
  input logic              bready,
  input logic              rvalid,
  input logic              rready,
  input logic              rlast,
  input logic              wr_err,
  input logic              rd_err
);
  logic [CNT_W:0] w_beats;

  always_ff @(posedge clk) begin
    if (rst)
      w_beats <= '0;
    else if (awvalid && awready)
      w_beats <= '0;
    else if (wvalid && wready)
      w_beats <= w_beats + 1'b1;
  end

  AST_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_cmd_valid && wr_cmd_ready |=> !wr_cmd_ready);  // R3
  AST_RD_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_cmd_valid && rd_cmd_ready |=> !rd_cmd_ready);  // R3
  AST_WR_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_cmd_ready) |-> $past(bvalid && bready));  // R4
  AST_RD_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_cmd_ready) |-> $past(rvalid && rready && rlast));  // R6
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));  // R2
  AST_WLAST_POS: assert property (@(posedge clk) disable iff (rst)
    wvalid |-> (wlast == (w_beats == {1'b0, awlen})));  // R5
  AST_W_AFTER_AW: assert property (@(posedge clk) disable iff (rst)
    wvalid |-> !awvalid && !wr_cmd_ready);  // R5
  AST_WERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);  // R7
  AST_RERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> rd_err);  // R7
endmodule

bind burst_dma_master burst_dma_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_checks (
  .clk          (clk),
  .rst          (rst),
  .wr_cmd_valid (wr_cmd_valid),
  .wr_cmd_ready (wr_cmd_ready),
  .rd_cmd_valid (rd_cmd_valid),
  .rd_cmd_ready (rd_cmd_ready),
  .awaddr       (awaddr),
  .awlen        (awlen),
  .awvalid      (awvalid),
  .awready      (awready),
  .wvalid       (wvalid),
  .wready       (wready),
  .wlast        (wlast),
  .bvalid       (bvalid),
  .bready       (bready),
  .rvalid       (rvalid),
  .rready       (rready),
  .rlast        (rlast),
  .wr_err       (wr_err),
  .rd_err       (rd_err)
);

// File: tb/test_burst_dma_master.sv
`timescale 1ns/1ps
module test_burst_dma_master;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] wr_cmd_addr, rd_cmd_addr;
  logic [7:0]  wr_cmd_count, rd_cmd_count;
  logic        wr_cmd_valid, wr_cmd_ready, rd_cmd_valid, rd_cmd_ready;
  logic [63:0] wr_data, rd_data;
  logic        wr_data_valid, wr_data_ready, rd_data_valid, rd_data_ready;
  logic [31:0] awaddr, araddr;
  logic [7:0]  awlen, arlen;
  logic [2:0]  awsize, arsize;
  logic [1:0]  awburst, arburst, bresp, rresp;
  logic        awvalid, awready, wlast, wvalid, wready, bvalid, bready;
  logic        arvalid, arready, rlast, rvalid, rready, wr_err, rd_err;
  logic [63:0] wdata, rdata;
  logic [7:0]  wstrb;

  always #2 clk = ~clk;

  burst_dma_master i_burst_dma_master (.*);

  int tests = 0, fails = 0;
  logic [63:0] mem [logic [31:0]];
  int wph = 0, rph = 0;               // 0 idle, 1 address, 2 data, 3 response
  logic [31:0] m_waddr, m_raddr;
  int m_wlen, m_rlen, wbeat, rbeat;
  logic m_werr = 1'b0, m_rerr = 1'b0;
  logic hs_b = 1'b0, hs_r = 1'b0, hs_wd = 1'b0;
  logic b_err = 1'b0, r_err = 1'b0;
  logic [31:0] seq = 32'd1;

  function automatic logic [63:0] exp_mem(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {32'hDEAD0000, a};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // cycle-by-cycle slave, stream source/sink and reference model
  always @(negedge clk) begin
    if (rst) begin
      wph = 0; rph = 0; m_werr = 0; m_rerr = 0;
      hs_b = 0; hs_r = 0; hs_wd = 0;
    end else begin
      awready = ($urandom % 4) != 0;
      wready  = ($urandom % 4) != 0;
      arready = ($urandom % 3) != 0;
      rd_data_ready = ($urandom % 4) != 0;
      if (hs_b) bvalid = 0;
      if (!bvalid) bvalid = (wph == 3) && (($urandom % 3) == 0);
      bresp = b_err ? 2'b10 : 2'b00;
      if (hs_r) rvalid = 0;
      if (!rvalid) rvalid = (rph == 2) && (($urandom % 4) != 0);
      rdata = exp_mem(m_raddr + 32'(8 * rbeat));
      rlast = (rph == 2) && (rbeat == m_rlen);
      rresp = r_err ? 2'b10 : 2'b00;
      if (hs_wd) begin wr_data_valid = 0; seq = seq + 1; end
      if (!wr_data_valid) wr_data_valid = ($urandom % 4) != 0;
      wr_data = {32'hC0DE0000 ^ seq, seq};
      hs_b = 0; hs_r = 0; hs_wd = 0;
      #1;
      // compare outputs against model state
      chk(wr_cmd_ready == (wph == 0), "R3/R4 wr_cmd_ready", 64'(wr_cmd_ready), 64'(wph == 0));
      chk(rd_cmd_ready == (rph == 0), "R3/R6 rd_cmd_ready", 64'(rd_cmd_ready), 64'(rph == 0));
      chk(awvalid == (wph == 1), "R2 awvalid", 64'(awvalid), 64'(wph == 1));
      chk(arvalid == (rph == 1), "R2 arvalid", 64'(arvalid), 64'(rph == 1));
      if (wph == 1) begin
        chk(awaddr == m_waddr, "R2 awaddr", 64'(awaddr), 64'(m_waddr));
        chk(awlen == 8'(m_wlen), "R2 awlen", 64'(awlen), 64'(m_wlen));
        chk(awsize == 3'd3 && awburst == 2'b01 && wstrb == 8'hFF, "R2 size/burst/strb",
            64'({awsize, awburst, wstrb}), 64'({3'd3, 2'b01, 8'hFF}));
      end
      if (rph == 1) begin
        chk(araddr == m_raddr, "R2 araddr", 64'(araddr), 64'(m_raddr));
        chk(arlen == 8'(m_rlen), "R2 arlen", 64'(arlen), 64'(m_rlen));
        chk(arsize == 3'd3 && arburst == 2'b01, "R2 arsize/arburst",
            64'({arsize, arburst}), 64'({3'd3, 2'b01}));
      end
      chk(wvalid == ((wph == 2) && wr_data_valid), "R5 wvalid", 64'(wvalid), 64'((wph == 2) && wr_data_valid));
      chk(wr_data_ready == ((wph == 2) && wready), "R5 wr_data_ready", 64'(wr_data_ready), 64'((wph == 2) && wready));
      if (wph == 2) begin
        chk(wdata == wr_data, "R5 wdata", wdata, wr_data);
        chk(wlast == (wbeat == m_wlen), "R5/R9 wlast", 64'(wlast), 64'(wbeat == m_wlen));
      end
      chk(bready == (wph == 3), "R4 bready", 64'(bready), 64'(wph == 3));
      chk(rready == ((rph == 2) && rd_data_ready), "R6 rready", 64'(rready), 64'((rph == 2) && rd_data_ready));
      chk(rd_data_valid == ((rph == 2) && rvalid), "R6 rd_data_valid", 64'(rd_data_valid), 64'((rph == 2) && rvalid));
      if (rph == 2 && rvalid) begin
        chk(rd_data == rdata, "R6 rd_data", rd_data, rdata);
        chk(rd_data == exp_mem(m_raddr + 32'(8 * rbeat)), "R6/R8 read-back data",
            rd_data, exp_mem(m_raddr + 32'(8 * rbeat)));
      end
      chk(wr_err == m_werr, "R7 wr_err", 64'(wr_err), 64'(m_werr));
      chk(rd_err == m_rerr, "R7 rd_err", 64'(rd_err), 64'(m_rerr));
      // advance the model by the handshakes of the coming edge
      case (wph)
        0: if (wr_cmd_valid) begin
             wph = 1; m_waddr = wr_cmd_addr; m_wlen = int'(wr_cmd_count); wbeat = 0;
           end
        1: if (awready) wph = 2;
        2: if (wr_data_valid && wready) begin
             hs_wd = 1;
             mem[m_waddr + 32'(8 * wbeat)] = wr_data;
             if (wbeat == m_wlen) wph = 3; else wbeat++;
           end
        3: if (bvalid) begin
             hs_b = 1; wph = 0;
             if (bresp != 2'b00) m_werr = 1;
           end
        default: wph = 0;
      endcase
      case (rph)
        0: if (rd_cmd_valid) begin
             rph = 1; m_raddr = rd_cmd_addr; m_rlen = int'(rd_cmd_count); rbeat = 0;
           end
        1: if (arready) rph = 2;
        2: if (rvalid && rd_data_ready) begin
             hs_r = 1;
             if (rresp != 2'b00) m_rerr = 1;
             if (rbeat == m_rlen) rph = 0; else rbeat++;
           end
        default: rph = 0;
      endcase
    end
  end

  task automatic do_write(logic [31:0] a, logic [7:0] c);
    @(posedge clk); #1;
    wr_cmd_addr = a; wr_cmd_count = c; wr_cmd_valid = 1;
    forever begin @(negedge clk); #2; if (wr_cmd_ready) break; end
    @(posedge clk); #1; wr_cmd_valid = 0;
    forever begin @(negedge clk); #2; if (wr_cmd_ready) break; end
  endtask

  task automatic do_read(logic [31:0] a, logic [7:0] c);
    @(posedge clk); #1;
    rd_cmd_addr = a; rd_cmd_count = c; rd_cmd_valid = 1;
    forever begin @(negedge clk); #2; if (rd_cmd_ready) break; end
    @(posedge clk); #1; rd_cmd_valid = 0;
    forever begin @(negedge clk); #2; if (rd_cmd_ready) break; end
  endtask

  initial begin
    rst = 1;
    wr_cmd_addr = 0; wr_cmd_count = 0; wr_cmd_valid = 0;
    rd_cmd_addr = 0; rd_cmd_count = 0; rd_cmd_valid = 0;
    wr_data = 0; wr_data_valid = 0; rd_data_ready = 0;
    awready = 0; wready = 0; bvalid = 0; bresp = 0;
    arready = 0; rvalid = 0; rdata = 0; rresp = 0; rlast = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1: reset state
    chk(wr_cmd_ready && rd_cmd_ready, "R1 cmd ready", 64'({wr_cmd_ready, rd_cmd_ready}), 64'b11);
    chk(!awvalid && !wvalid && !arvalid, "R1 valids low", 64'({awvalid, wvalid, arvalid}), 64'b0);
    chk(!bready && !rready, "R1 readies low", 64'({bready, rready}), 64'b0);
    chk(!wr_err && !rd_err, "R1 error flags", 64'({wr_err, rd_err}), 64'b0);
    @(posedge clk); #1 rst = 0;
    // R2 R5 R6: basic burst, then read-back
    do_write(32'h1000, 8'd3);
    do_read(32'h1000, 8'd3);
    // R9: single-word transfers
    do_write(32'h1800, 8'd0);
    do_read(32'h1800, 8'd0);
    // R8: both sides at once
    fork
      do_write(32'h2000, 8'd15);
      do_read(32'h1000, 8'd3);
    join
    do_read(32'h2000, 8'd15);
    // R9: largest burst
    fork
      do_write(32'h3000, 8'd255);
      do_read(32'h2000, 8'd15);
    join
    do_read(32'h3000, 8'd255);
    // R7: error responses, sticky and non-blocking
    b_err = 1; do_write(32'h4000, 8'd2); b_err = 0;
    do_write(32'h4100, 8'd1);
    do_read(32'h4100, 8'd1);
    r_err = 1; do_read(32'h4000, 8'd2); r_err = 0;
    do_read(32'h4100, 8'd1);
    @(negedge clk); #1;
    chk(wr_err && rd_err, "R7 flags stay set", 64'({wr_err, rd_err}), 64'b11);
    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual still busy expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule